// File: doc/BRIEF.md
# Hub-to-Core Image Loader

This block copies a program image from shared hub memory into the 512-long local RAM of one core and then starts that core. A launch request arrives as a single 32-bit descriptor word together with a mode flag. The descriptor packs three things: a flag that marks it as a load, the number of longs to copy, and the hub long address to copy from. Once a request is accepted, the loader reads the image one long at a time over a request/grant/valid hub port. Each returned long is written into local RAM, starting at local address 0 and counting upward. When the last long has been stored, the loader pulses `done` and presents an entry PC of 0.

In fast mode, each hub grant returns an eight-long wide beat. This mode needs a source that sits on an eight-long (32-byte) boundary. If the source is not aligned, the loader falls back to single-long reads without any fault. A load never reaches the top sixteen local registers: requested counts above 0x1F0 are clamped to that value. Arbitration between cores is not part of this block. A single grant input stands for it.

The controller is one state machine with five states:
- **IDLE** waits for a request. It moves to ISSUE on an accepted request with a count above zero, and to FINISH on an accepted request with a count of zero.
- **ISSUE** holds the hub request and moves to WAIT on grant.
- **WAIT** moves to STORE on the first returned data.
- **STORE** writes one long per cycle. When the beat is used up it goes back to ISSUE if longs remain, or on to FINISH after the last one.
- **FINISH** pulses done and returns to IDLE.

Top module: `image_loader`

## Requirements
- R1: After reset, `busy`, `done`, `hub_req` and `ram_we` are all low.
- R2: A `start` seen in IDLE is accepted only when descriptor bit 31 is 1. With bit 31 at 0 the request is ignored: `busy` stays low and there is no hub request and no RAM write.
- R3: The load count is taken from descriptor bits 20:12 and the hub source long address from bits 11:0. Bits 30:21 have no effect.
- R4: In single-long mode, long i is requested at hub address (source + i) modulo 4096 with `hub_wide` low. Its data, taken from `hub_rdata[31:0]`, is written to local address i, in ascending order.
- R5: When `fast` is 1 and source bits 2:0 are zero, beat k is requested at source + 8k with `hub_wide` high. Lane j, taken from `hub_rdata[32j+31:32j]`, is written to local address 8k+j.
- R6: In fast mode, a count that is not a multiple of eight is rounded up to whole beats, and no RAM write occurs at any local address equal to or above the count.
- R7: When `fast` is 1 with a source whose bits 2:0 are not zero, the load runs in single-long mode as in R4.
- R8: A count above 496 loads exactly 496 longs (addresses 0x000 to 0x1EF). No write ever targets 0x1F0 to 0x1FF.
- R9: A count of zero raises `done` in the cycle after acceptance, with no hub request and no RAM write.
- R10: `done` is a single-cycle pulse with `start_pc` equal to 0, issued after the last write. `busy` is high from the cycle after acceptance through the `done` cycle, and low the cycle after.
- R11: A `start` that arrives while `busy` is high has no effect on the running load.
- R12: `hub_req` stays high with a stable `hub_addr` until a cycle in which `hub_gnt` is high. Only one request is outstanding at a time, and its data is taken on the next `hub_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request strobe |
| desc | input | 32 | Launch descriptor (flag, count, source) |
| fast | input | 1 | Request wide-beat mode |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| start_pc | output | 9 | Entry address presented with done |
| hub_req | output | 1 | Hub read request |
| hub_wide | output | 1 | Request is an eight-long beat |
| hub_addr | output | 12 | Hub long address of the request |
| hub_gnt | input | 1 | Hub accepts the request this cycle |
| hub_rvalid | input | 1 | Read data valid |
| hub_rdata | input | 256 | Read data, lane j in bits 32j+31:32j |
| ram_we | output | 1 | Local RAM write enable |
| ram_waddr | output | 9 | Local RAM write address |
| ram_wdata | output | 32 | Local RAM write data |

## Verification
The bench builds the loader with its default parameters:
- eight-long beats,
- a 512-entry local RAM,
- a load limit of 496,
- a 12-bit hub address.

With a 9-bit count field, the largest count of 511 lies above the limit. This puts the clamp at 0x1EF within reach in both modes. The 12-bit hub address also lets a short single-long load cross from 0xFFF to 0x000. With eight lanes, a count of 13 gives one full beat and one partial beat, which exercises the write masking. The grant pattern is varied between loads, so the request is held across denied cycles as well as granted at once.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ISSUE  = 3'd1,
        S_WAIT   = 3'd2,
        S_STORE  = 3'd3,
        S_FINISH = 3'd4
    } ldr_state_t;

endpackage

// File: rtl/ldr_decode.sv
module ldr_decode #(
    parameter int LONG_W     = 32,
    parameter int HUB_AW     = 12,
    parameter int CNT_W      = 9,
    parameter int IDX_W      = 10,
    parameter int LANE_W     = 3,
    parameter int LOAD_LIMIT = 496
) (
    input  logic [LONG_W-1:0] desc,
    input  logic              fast,
    output logic              launch_ok,
    output logic [IDX_W-1:0]  count,
    output logic [HUB_AW-1:0] src,
    output logic              wide
);
    localparam int RSV_LO = HUB_AW + CNT_W;

    logic [CNT_W-1:0] raw_count;
    logic             dec_unused;

    assign raw_count  = desc[HUB_AW +: CNT_W];
    assign launch_ok  = desc[LONG_W-1];
    assign src        = desc[HUB_AW-1:0];
    assign dec_unused = ^desc[LONG_W-2:RSV_LO];

    always_comb begin
        if (IDX_W'(raw_count) > IDX_W'(LOAD_LIMIT)) begin
            count = IDX_W'(LOAD_LIMIT);
        end else begin
            count = IDX_W'(raw_count);
        end
        wide = fast && (src[LANE_W-1:0] == '0);
    end

endmodule

// File: rtl/ldr_lane_mux.sv
module ldr_lane_mux #(
    parameter int LONG_W = 32,
    parameter int LANES  = 8,
    parameter int LANE_W = 3
) (
    input  logic [LONG_W*LANES-1:0] beat,
    input  logic [LANE_W-1:0]       sel,
    output logic [LONG_W-1:0]       word
);
    logic [LONG_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = beat[g*LONG_W +: LONG_W];
    end

    assign word = lanes[sel];

endmodule

// File: rtl/image_loader.sv
module image_loader
    import ldr_pkg::*;
#(
    parameter int LONG_W     = 32,
    parameter int LANES      = 8,
    parameter int RAM_DEPTH  = 512,
    parameter int LOAD_LIMIT = 496,
    parameter int HUB_AW     = 12,
    parameter int CNT_W      = 9,
    parameter int ENTRY_PC   = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [LONG_W-1:0]            desc,
    input  logic                         fast,
    output logic                         busy,
    output logic                         done,
    output logic [$clog2(RAM_DEPTH)-1:0] start_pc,
    output logic                         hub_req,
    output logic                         hub_wide,
    output logic [HUB_AW-1:0]            hub_addr,
    input  logic                         hub_gnt,
    input  logic                         hub_rvalid,
    input  logic [LONG_W*LANES-1:0]      hub_rdata,
    output logic                         ram_we,
    output logic [$clog2(RAM_DEPTH)-1:0] ram_waddr,
    output logic [LONG_W-1:0]            ram_wdata
);
    localparam int RAM_AW = $clog2(RAM_DEPTH);
    localparam int LANE_W = $clog2(LANES);
    localparam int IDX_W  = RAM_AW + 1;
    localparam int BEAT_W = LONG_W * LANES;

    ldr_state_t state, state_nx;

    logic [IDX_W-1:0]  cnt_q;
    logic [HUB_AW-1:0] src_q;
    logic              wide_q;
    logic [HUB_AW-1:0] issue_off;
    logic [IDX_W-1:0]  wr_idx;
    logic [LANE_W-1:0] lane_q;
    logic [BEAT_W-1:0] beat_q;

    logic              dec_ok;
    logic [IDX_W-1:0]  dec_count;
    logic [HUB_AW-1:0] dec_src;
    logic              dec_wide;
    logic [LONG_W-1:0] lane_word;

    logic accept;
    logic beat_end;
    logic last_long;

    ldr_decode #(
        .LONG_W    (LONG_W),
        .HUB_AW    (HUB_AW),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W),
        .LANE_W    (LANE_W),
        .LOAD_LIMIT(LOAD_LIMIT)
    ) u_decode (
        .desc     (desc),
        .fast     (fast),
        .launch_ok(dec_ok),
        .count    (dec_count),
        .src      (dec_src),
        .wide     (dec_wide)
    );

    ldr_lane_mux #(
        .LONG_W(LONG_W),
        .LANES (LANES),
        .LANE_W(LANE_W)
    ) u_lane (
        .beat(beat_q),
        .sel (lane_q),
        .word(lane_word)
    );

    assign accept    = start && dec_ok;
    assign beat_end  = !wide_q || (lane_q == LANE_W'(LANES - 1));
    assign last_long = (wr_idx + IDX_W'(1)) >= cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    state_nx = (dec_count == '0) ? S_FINISH : S_ISSUE;
                end
            end
            S_ISSUE: begin
                if (hub_gnt) begin
                    state_nx = S_WAIT;
                end
            end
            S_WAIT: begin
                if (hub_rvalid) begin
                    state_nx = S_STORE;
                end
            end
            S_STORE: begin
                if (beat_end) begin
                    state_nx = last_long ? S_FINISH : S_ISSUE;
                end
            end
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            src_q     <= '0;
            wide_q    <= 1'b0;
            issue_off <= '0;
            wr_idx    <= '0;
            lane_q    <= '0;
            beat_q    <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        cnt_q     <= dec_count;
                        src_q     <= dec_src;
                        wide_q    <= dec_wide;
                        issue_off <= '0;
                        wr_idx    <= '0;
                        lane_q    <= '0;
                    end
                end
                S_ISSUE: begin
                    if (hub_gnt) begin
                        issue_off <= issue_off + (wide_q ? HUB_AW'(LANES) : HUB_AW'(1));
                    end
                end
                S_WAIT: begin
                    if (hub_rvalid) begin
                        beat_q <= hub_rdata;
                        lane_q <= '0;
                    end
                end
                S_STORE: begin
                    wr_idx <= wr_idx + IDX_W'(1);
                    lane_q <= lane_q + LANE_W'(1);
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_FINISH);
        start_pc  = done ? RAM_AW'(ENTRY_PC) : '0;
        hub_req   = (state == S_ISSUE);
        hub_wide  = hub_req && wide_q;
        hub_addr  = src_q + issue_off;
        ram_we    = (state == S_STORE) && (wr_idx < cnt_q);
        ram_waddr = wr_idx[RAM_AW-1:0];
        ram_wdata = lane_word;
    end

endmodule

// File: rtl/image_loader_chk.sv
module image_loader_chk #(
    parameter int RAM_AW     = 9,
    parameter int HUB_AW     = 12,
    parameter int LANE_W     = 3,
    parameter int LOAD_LIMIT = 496
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              hub_req,
    input logic              hub_gnt,
    input logic              hub_wide,
    input logic [HUB_AW-1:0] hub_addr,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_waddr
);

    p_done_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    p_below_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (int'(ram_waddr) < LOAD_LIMIT));

    p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_req && !hub_gnt) |=> (hub_req && $stable(hub_addr)));

    p_wide_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_req && hub_wide) |-> (hub_addr[LANE_W-1:0] == '0));

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!hub_req && !ram_we));

    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

bind image_loader image_loader_chk #(
    .RAM_AW    ($clog2(RAM_DEPTH)),
    .HUB_AW    (HUB_AW),
    .LANE_W    ($clog2(LANES)),
    .LOAD_LIMIT(LOAD_LIMIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .hub_req  (hub_req),
    .hub_gnt  (hub_gnt),
    .hub_wide (hub_wide),
    .hub_addr (hub_addr),
    .ram_we   (ram_we),
    .ram_waddr(ram_waddr)
);

// File: tb/sim_image_loader.sv
`timescale 1ns/1ps
module sim_image_loader;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  desc = '0;
    logic         fast = 1'b0;
    logic         busy, done, hub_req, hub_wide, ram_we;
    logic [8:0]   start_pc, ram_waddr;
    logic [11:0]  hub_addr;
    logic         hub_gnt = 1'b0;
    logic         hub_rvalid = 1'b0;
    logic [255:0] hub_rdata = '0;
    logic [31:0]  ram_wdata;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    image_loader u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .desc(desc), .fast(fast),
        .busy(busy), .done(done), .start_pc(start_pc),
        .hub_req(hub_req), .hub_wide(hub_wide), .hub_addr(hub_addr),
        .hub_gnt(hub_gnt), .hub_rvalid(hub_rvalid), .hub_rdata(hub_rdata),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
    );

    // reference model state
    int          exp_req_addr[$];
    bit          exp_req_wide[$];
    int          exp_wr_addr[$];
    logic [31:0] exp_wr_data[$];
    string       cur_tag = "R1";
    int          gnt_period = 1;
    int          gnt_tick = 0;
    int          pend_cnt = 0;
    int          pend_addr = 0;
    bit          pend_wide = 0;

    function automatic logic [31:0] hub_word(int a);
        logic [11:0] w;
        w = 12'(a);
        return {8'h5A, w, ~w};
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural hub and per-clock comparison
    always @(negedge clk) begin
        hub_rvalid = 1'b0;
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
                hub_rvalid = 1'b1;
                for (int j = 0; j < 8; j++) begin
                    hub_rdata[j*32 +: 32] = pend_wide ? hub_word(pend_addr + j)
                                                      : ((j == 0) ? hub_word(pend_addr) : 32'hDEAD_0000);
                end
            end
        end
        gnt_tick++;
        hub_gnt = (gnt_period <= 1) ? 1'b1 : ((gnt_tick % gnt_period) == 0);
        if (rst_n && hub_req && hub_gnt) begin
            if (exp_req_addr.size() == 0) begin
                check(0, cur_tag, "unexpected hub request", hub_addr, 0);
            end else begin
                int ea;
                bit ew;
                ea = exp_req_addr.pop_front();
                ew = exp_req_wide.pop_front();
                check(int'(hub_addr) == ea, cur_tag, "request address (R12)", hub_addr, ea);
                check(hub_wide == ew, cur_tag, "request width", hub_wide, ew);
            end
            pend_cnt = 2;
            pend_addr = int'(hub_addr);
            pend_wide = hub_wide;
        end
        if (rst_n && ram_we) begin
            if (exp_wr_addr.size() == 0) begin
                check(0, cur_tag, "unexpected RAM write", ram_waddr, 0);
            end else begin
                int          wa;
                logic [31:0] wd;
                wa = exp_wr_addr.pop_front();
                wd = exp_wr_data.pop_front();
                check(int'(ram_waddr) == wa, cur_tag, "write address", ram_waddr, wa);
                check(ram_wdata == wd, cur_tag, "write data", ram_wdata, wd);
            end
        end
    end

    task automatic build(logic [31:0] d, bit f);
        int  cnt, src;
        bit  wd;
        exp_req_addr.delete(); exp_req_wide.delete();
        exp_wr_addr.delete();  exp_wr_data.delete();
        cnt = int'(d[20:12]);
        if (cnt > 496) cnt = 496;
        src = int'(d[11:0]);
        wd  = f && (src % 8 == 0);
        if (wd) begin
            for (int k = 0; k < (cnt + 7) / 8; k++) begin
                exp_req_addr.push_back((src + 8 * k) % 4096);
                exp_req_wide.push_back(1'b1);
            end
        end else begin
            for (int i = 0; i < cnt; i++) begin
                exp_req_addr.push_back((src + i) % 4096);
                exp_req_wide.push_back(1'b0);
            end
        end
        for (int i = 0; i < cnt; i++) begin
            exp_wr_addr.push_back(i);
            exp_wr_data.push_back(hub_word((src + i) % 4096));
        end
    endtask

    task automatic run_load(string tag, logic [31:0] d, bit f, int gp, int poke_at, int exp_cycles);
        int  cyc;
        bit  busy_ok;
        cur_tag = tag;
        gnt_period = gp;
        build(d, f);
        @(negedge clk);
        desc = d; fast = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0; desc = 32'h8000_5123; fast = 1'b0;
        cyc = 1;
        busy_ok = 1;
        while (!done && cyc < 20000) begin
            if (!busy) busy_ok = 0;
            if (poke_at > 0 && cyc == poke_at) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(done == 1'b1, tag, "done reached (R10)", done, 1);
        check(busy_ok && busy, tag, "busy held until done (R10)", busy, 1);
        check(start_pc == 9'd0, tag, "start_pc with done (R10)", start_pc, 0);
        check(exp_wr_addr.size() == 0, tag, "writes outstanding", exp_wr_addr.size(), 0);
        check(exp_req_addr.size() == 0, tag, "requests outstanding", exp_req_addr.size(), 0);
        if (exp_cycles > 0) check(cyc == exp_cycles, tag, "cycles to done", cyc, exp_cycles);
        @(negedge clk);
        check(!busy && !done, tag, "idle after done (R10)", {busy, done}, 0);
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired tag=%s actual=running expected=finished", cur_tag);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !hub_req && !ram_we, "R1", "reset outputs",
              {busy, done, hub_req, ram_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !hub_req && !ram_we, "R1", "after reset release",
              {busy, done, hub_req, ram_we}, 0);

        // R4 single-long load
        run_load("R4", 32'h8000_5010, 1'b0, 1, 0, 0);
        // R4 hub address wrap with delayed grants
        run_load("R4_wrap", 32'h8000_4FFE, 1'b0, 3, 0, 0);
        // R5 aligned wide load
        run_load("R5", 32'h8001_0040, 1'b1, 2, 0, 0);
        // R6 partial last beat
        run_load("R6", 32'h8000_D080, 1'b1, 1, 0, 0);
        // R7 unaligned fast falls back to single
        run_load("R7", 32'h8000_6083, 1'b1, 2, 0, 0);
        // R8 clamp in fast mode
        run_load("R8_fast", 32'h801F_F000, 1'b1, 1, 0, 0);
        // R8 clamp in single mode
        run_load("R8_single", 32'h801F_4200, 1'b0, 1, 0, 0);
        // R9 zero count finishes in one cycle
        run_load("R9", 32'h8000_0123, 1'b1, 1, 0, 1);
        // R3 reserved bits have no effect
        run_load("R3", 32'hFFE0_3456, 1'b0, 1, 0, 0);
        // R11 start while busy is ignored
        run_load("R11", 32'h8000_A300, 1'b0, 2, 7, 0);

        // R2 descriptor without load flag is ignored
        cur_tag = "R2";
        exp_req_addr.delete(); exp_req_wide.delete();
        exp_wr_addr.delete();  exp_wr_data.delete();
        @(negedge clk);
        desc = 32'h0000_5040; fast = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 6; i++) begin
            check(!busy && !done, "R2", "no launch without flag", {busy, done}, 0);
            @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule